// File: doc/BRIEF.md
# Segmented Linear Address Generator

This block turns a segment selector and an effective offset into a linear address. In real mode, it shifts the 16-bit selector left by four bits and adds the low 16 bits of the offset. The sum wraps inside a 1 MiB window. In protected mode, the selector picks an 8-byte descriptor from one of two internal tables, global or local. The 32-bit base held in that descriptor is added to the full offset.

A write port fills the two tables. A request is accepted on any cycle, and its result appears exactly one cycle later. Each result carries a flag that says whether the address is already physical or must still go through paging. A protected-mode null selector gives a fault instead of an address.

The result logic is a small state machine with four named states:
- `ST_IDLE`: no result this cycle.
- `ST_REAL`: a real-mode result is shown.
- `ST_PROT`: a protected-mode result is shown.
- `ST_NULL`: a null-selector fault is shown.

On every clock edge, the state moves to the state that matches the request presented on that edge. With no request, it moves to `ST_IDLE`. Reset also forces `ST_IDLE`.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is held and after it is released with no request, `rsp_valid`, `needs_xlate` and `null_fault` are low.
- R2: A request sampled on a clock edge makes `rsp_valid` high for exactly the following cycle. With no request on an edge, `rsp_valid` is low in the following cycle.
- R3: In real mode (`prot_mode`=0), `lin_addr` = (`selector` << 4) + `offset[15:0]`. Bits 31:16 of the offset have no effect.
- R4: A real-mode result keeps only 20 bits, so `lin_addr[31:20]` is zero and sums of 1 MiB or more wrap.
- R5: In protected mode, `selector[2]` chooses the table: 0 selects global and 1 selects local. The entry index is the low `IDX_W` bits of `selector[15:3]`.
- R6: The descriptor base is assembled from scattered fields, with descriptor byte k held in `tbl_wr_data[8k+7:8k]`:
  - base[15:0] comes from bytes 2–3;
  - base[23:16] comes from byte 4;
  - base[31:24] comes from byte 7.
  The other bytes are ignored.
- R7: In protected mode, `lin_addr` = base + `offset`, modulo 2^32.
- R8: For a non-fault result, `needs_xlate` equals the `paging_en` value sampled with the request.
- R9: In protected mode, a selector with `selector[15:3]`=0 and `selector[2]`=0 raises `null_fault` with `lin_addr`=0 and `needs_xlate`=0. A zero selector in real mode, or a local selector with index 0, does not fault.
- R10: A table write goes only to the entry and table it names, and it is visible to requests on later edges. The other table keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| prot_mode | input | 1 | 1 = protected mode, 0 = real mode |
| paging_en | input | 1 | Paging enable sampled with the request |
| selector | input | 16 | Segment selector |
| offset | input | 32 | Effective offset |
| tbl_wr_en | input | 1 | Descriptor write strobe |
| tbl_wr_local | input | 1 | Write target: 1 = local table, 0 = global table |
| tbl_wr_idx | input | IDX_W | Entry written |
| tbl_wr_data | input | 64 | Descriptor bytes 0..7, byte 0 in the low bits |
| rsp_valid | output | 1 | Result valid |
| lin_addr | output | 32 | Linear address |
| needs_xlate | output | 1 | Address must pass through paging |
| null_fault | output | 1 | Null-selector fault |

## Verification
The embedded properties assume three things about the inputs:
- `prot_mode` and `paging_en` are meaningful on every edge where `req_valid` is high.
- No descriptor write targets the entry being read on the same edge.
- Every table entry used by a request has been written beforehand.

The bench drives all inputs at the falling edge. It loads each descriptor several cycles before the first request that reads it, and it never overlaps a write with a read of the same entry. The bench then samples each result at the falling edge that follows the accepting rising edge.

// File: rtl/seg_pkg.sv
package seg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REAL = 2'd1,
        ST_PROT = 2'd2,
        ST_NULL = 2'd3
    } res_state_t;

    localparam int REAL_W = 20;

    // Gather the 32-bit segment base from its three descriptor fields.
    function automatic logic [31:0] desc_base(input logic [63:0] d);
        return {d[63:56], d[39:32], d[31:16]};
    endfunction

endpackage

// File: rtl/desc_table.sv
module desc_table #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [63:0]      wr_data,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [63:0]      rd_data
);
    logic [63:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
        if (rd_en) begin
            rd_data <= mem[rd_idx];
        end
    end
endmodule

// File: rtl/addr_form.sv
module addr_form
    import seg_pkg::*;
(
    input  logic [15:0] sel_q,
    input  logic [31:0] off_q,
    input  logic [63:0] desc_q,
    output logic [31:0] real_lin,
    output logic [31:0] prot_lin
);
    logic [REAL_W-1:0] real_sum;

    always_comb begin
        real_sum = {sel_q, 4'b0000} + {4'b0000, off_q[15:0]};
        real_lin = {{(32-REAL_W){1'b0}}, real_sum};
        prot_lin = desc_base(desc_q) + off_q;
    end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             prot_mode,
    input  logic             paging_en,
    input  logic [15:0]      selector,
    input  logic [31:0]      offset,
    input  logic             tbl_wr_en,
    input  logic             tbl_wr_local,
    input  logic [IDX_W-1:0] tbl_wr_idx,
    input  logic [63:0]      tbl_wr_data,
    output logic             rsp_valid,
    output logic [31:0]      lin_addr,
    output logic             needs_xlate,
    output logic             null_fault
);
    localparam int NUM_TBL = 2;

    res_state_t  state_q, state_d;
    logic [15:0] sel_q;
    logic [31:0] off_q;
    logic        pg_q;
    logic        ti_q;
    logic [63:0] desc_rd [NUM_TBL];
    logic [31:0] real_lin, prot_lin;
    logic        is_null;

    assign is_null = (selector[15:2] == 14'd0);

    // Table 0 is global, table 1 is local.
    for (genvar gi = 0; gi < NUM_TBL; gi++) begin : g_tbl
        desc_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_tbl (
            .clk     (clk),
            .wr_en   (tbl_wr_en && (tbl_wr_local == gi[0])),
            .wr_idx  (tbl_wr_idx),
            .wr_data (tbl_wr_data),
            .rd_en   (req_valid && prot_mode && (selector[2] == gi[0])),
            .rd_idx  (selector[3 +: IDX_W]),
            .rd_data (desc_rd[gi])
        );
    end

    addr_form u_form (
        .sel_q    (sel_q),
        .off_q    (off_q),
        .desc_q   (desc_rd[ti_q]),
        .real_lin (real_lin),
        .prot_lin (prot_lin)
    );

    always_comb begin
        state_d = ST_IDLE;
        if (req_valid) begin
            if (!prot_mode)   state_d = ST_REAL;
            else if (is_null) state_d = ST_NULL;
            else              state_d = ST_PROT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
            off_q   <= '0;
            pg_q    <= 1'b0;
            ti_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                sel_q <= selector;
                off_q <= offset;
                pg_q  <= paging_en;
                ti_q  <= selector[2];
            end
        end
    end

    always_comb begin
        rsp_valid   = 1'b0;
        lin_addr    = '0;
        needs_xlate = 1'b0;
        null_fault  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_REAL: begin
                rsp_valid   = 1'b1;
                lin_addr    = real_lin;
                needs_xlate = pg_q;
            end
            ST_PROT: begin
                rsp_valid   = 1'b1;
                lin_addr    = prot_lin;
                needs_xlate = pg_q;
            end
            ST_NULL: begin
                rsp_valid  = 1'b1;
                null_fault = 1'b1;
            end
            default: ;
        endcase
    end

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R4
    real_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !prot_mode) |=> (lin_addr[31:20] == 12'd0));

    // R8
    xlate_tracks_paging_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !(prot_mode && selector[15:2] == 14'd0)) |=> (needs_xlate == $past(paging_en)));

    // R9
    null_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        null_fault |-> (lin_addr == 32'd0 && !needs_xlate && rsp_valid));

    // R9
    null_only_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !prot_mode) |=> !null_fault);
endmodule

// File: tb/tb_seg_addr_gen.sv
module tb_seg_addr_gen;
    localparam int ENTRIES = 8;
    localparam int IDX_W   = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             prot_mode = 1'b0;
    logic             paging_en = 1'b0;
    logic [15:0]      selector = '0;
    logic [31:0]      offset = '0;
    logic             tbl_wr_en = 1'b0;
    logic             tbl_wr_local = 1'b0;
    logic [IDX_W-1:0] tbl_wr_idx = '0;
    logic [63:0]      tbl_wr_data = '0;
    logic             rsp_valid;
    logic [31:0]      lin_addr;
    logic             needs_xlate;
    logic             null_fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    seg_addr_gen #(.ENTRIES(ENTRIES)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .prot_mode(prot_mode),
        .paging_en(paging_en), .selector(selector), .offset(offset),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_local(tbl_wr_local), .tbl_wr_idx(tbl_wr_idx),
        .tbl_wr_data(tbl_wr_data), .rsp_valid(rsp_valid), .lin_addr(lin_addr),
        .needs_xlate(needs_xlate), .null_fault(null_fault)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_desc(input logic [31:0] base, input logic [7:0] fill);
        return {base[31:24], fill, fill, base[23:16], base[15:0], fill, fill};
    endfunction

    task automatic write_desc(input bit local_t, input int idx, input logic [63:0] d);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_local = local_t;
        tbl_wr_idx = IDX_W'(idx); tbl_wr_data = d;
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    // Drive at a falling edge; result visible at the next falling edge.
    task automatic issue(input bit pm, input bit pg, input logic [15:0] sel, input logic [31:0] off);
        @(negedge clk);
        req_valid = 1'b1; prot_mode = pm; paging_en = pg; selector = sel; offset = off;
        @(negedge clk);
        req_valid = 1'b0; prot_mode = 1'b0; paging_en = 1'b0;
    endtask

    task automatic expect_result(input string req, input logic [31:0] a,
                                 input bit xl, input bit flt);
        check({req, " valid"}, 32'(rsp_valid), 32'd1);
        check({req, " addr"}, lin_addr, a);
        check({req, " xlate"}, 32'(needs_xlate), 32'(xl));
        check({req, " fault"}, 32'(null_fault), 32'(flt));
    endtask

    task automatic t_reset;
        check("R1 valid in reset", 32'(rsp_valid), 32'd0);
        check("R1 fault in reset", 32'(null_fault), 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", 32'(rsp_valid), 32'd0);
        check("R1 xlate after reset", 32'(needs_xlate), 32'd0);
    endtask

    task automatic t_real;
        issue(1'b0, 1'b0, 16'h1234, 32'hABCD_0010);
        expect_result("R3 real", 32'h0001_2350, 1'b0, 1'b0);
        @(negedge clk);
        check("R2 single pulse", 32'(rsp_valid), 32'd0);
        issue(1'b0, 1'b0, 16'hFFFF, 32'h0000_FFFF);
        expect_result("R4 real wrap", 32'h0000_FFEF, 1'b0, 1'b0);
        issue(1'b0, 1'b0, 16'h0000, 32'h0000_0000);
        expect_result("R9 real zero selector", 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_tables;
        write_desc(1'b0, 1, mk_desc(32'h1020_3040, 8'hA5));
        write_desc(1'b1, 1, mk_desc(32'h5566_7788, 8'h3C));
        write_desc(1'b1, 0, mk_desc(32'h0000_1000, 8'hFF));
        write_desc(1'b0, 5, mk_desc(32'hFFFF_FF00, 8'h00));
        repeat (2) @(negedge clk);
        issue(1'b1, 1'b0, 16'h0008, 32'h0000_0004);
        expect_result("R5 R6 global idx1", 32'h1020_3044, 1'b0, 1'b0);
        issue(1'b1, 1'b1, 16'h000C, 32'h0000_0010);
        expect_result("R5 R8 local idx1", 32'h5566_7798, 1'b1, 1'b0);
        issue(1'b1, 1'b0, 16'h0004, 32'h0000_0020);
        expect_result("R9 local idx0 no fault", 32'h0000_1020, 1'b0, 1'b0);
        issue(1'b1, 1'b1, 16'h0028, 32'h0000_0200);
        expect_result("R7 wrap", 32'h0000_0100, 1'b1, 1'b0);
    endtask

    task automatic t_null;
        issue(1'b1, 1'b1, 16'h0003, 32'h1234_5678);
        expect_result("R9 null selector", 32'h0, 1'b0, 1'b1);
    endtask

    task automatic t_rewrite;
        write_desc(1'b0, 1, mk_desc(32'h0A0B_0C0D, 8'h11));
        repeat (2) @(negedge clk);
        issue(1'b1, 1'b0, 16'h0008, 32'h0);
        expect_result("R10 global rewritten", 32'h0A0B_0C0D, 1'b0, 1'b0);
        issue(1'b1, 1'b0, 16'h000C, 32'h0);
        expect_result("R10 local kept", 32'h5566_7788, 1'b0, 1'b0);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        req_valid = 1'b1; prot_mode = 1'b0; paging_en = 1'b1; selector = 16'h0100; offset = 32'h5;
        @(negedge clk);
        expect_result("R2 R8 b2b first", 32'h0000_1005, 1'b1, 1'b0);
        prot_mode = 1'b1; paging_en = 1'b0; selector = 16'h0008; offset = 32'h1;
        @(negedge clk);
        req_valid = 1'b0; prot_mode = 1'b0;
        expect_result("R2 b2b second", 32'h0A0B_0C0E, 1'b0, 1'b0);
        @(negedge clk);
        check("R2 idle after b2b", 32'(rsp_valid), 32'd0);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        t_reset();
        t_real();
        t_tables();
        t_null();
        t_rewrite();
        t_back_to_back();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end
endmodule